// File: doc/BRIEF.md
# Planar Write Bit-Mask Merge

This block is the last stage on the processor write path into a frame buffer that is split into four parallel byte planes. When the processor reads a byte address, the four plane bytes that come back are captured in four read latches. When the processor later writes, the upstream shifting, logic-operation and fill stages have already produced one candidate byte per plane. This block combines each candidate byte with that plane's latched byte, bit by bit, under one 8-bit mask that is shared by all planes. The merged plane bytes are then passed to memory together with the plane write enables, which go through unchanged.

The mask is reached through an index/data register pair. Software first writes the index register. A data write then lands in the mask only when the index holds 08h. A data read returns the mask at that index and zero at every other index. The intended sequence is a read that fills the latches, then mask setup, then the write. Only the bits that the mask selects take new data. Every other bit is rewritten with what was read.

The write path is a valid/ready stream with no storage. The output's valid follows the input's valid, and the input's ready follows the output's ready, in the same cycle. A transfer happens on a clock edge where valid and ready are both high. The upstream stage must hold its data and plane enables stable while valid is high and ready is low. The latch load port is a plain strobe without back-pressure.

Top module: `planar_wmask`

## Requirements
- R1: The index register resets to 00h. While it holds 08h, `dat_rdata` returns the mask register. At any other index value, `dat_rdata` is 00h.
- R2: A data write while the index is 08h replaces the mask from the next cycle onward. A data write at any other index leaves the mask unchanged.
- R3: A cycle with `ld_valid` high loads all four latches from `ld_data`, with plane p taken from bits [8p+7:8p]. The new values take effect from the next cycle.
- R4: For each plane p and bit b, `out_data[8p+b]` equals `in_data[8p+b]` when mask bit b is 1. It equals latch p bit b when mask bit b is 0. The same mask applies to all four planes.
- R5: The latches change only when loaded. Completed write transfers and mask changes leave them as they are.
- R6: `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_plane_en` equals `in_plane_en` (bit p enables plane p), all in the same cycle.
- R7: If a latch load or a mask write falls in the same cycle as a write, that write uses the latch and mask values held before the edge.
- R8: Reset clears all four latches to zero. The mask has no reset value and must be programmed before any write is relied on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Index register write strobe |
| idx_wdata | input | 8 | Index value |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Data register write value |
| dat_rdata | output | 8 | Data register read value at current index |
| ld_valid | input | 1 | Frame-buffer read return, loads latches |
| ld_data | input | 32 | Four plane bytes read, plane p at [8p+7:8p] |
| in_valid | input | 1 | Processed write data valid |
| in_ready | output | 1 | Processed write data accepted |
| in_data | input | 32 | Processed write bytes, plane p at [8p+7:8p] |
| in_plane_en | input | 4 | Plane write enables |
| out_valid | output | 1 | Merged write valid |
| out_ready | input | 1 | Memory accepts merged write |
| out_data | output | 32 | Merged plane bytes |
| out_plane_en | output | 4 | Plane write enables, passed through |

## Verification
A latch load or a mask update can arrive in the same cycle as a write beat. In that cycle the merge must still use the values held before the edge. The bench provokes each case on purpose. It holds a known latch pattern, then asserts `ld_valid` with a different pattern in the same cycle as `in_valid`, or asserts a mask data write alongside the beat. It requires the merged bytes to reflect the old values before the edge and the new ones on the following cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned PWM_PLANES   = 4;
  localparam int unsigned PWM_BYTE_W   = 8;
  localparam int unsigned PWM_IDX_W    = 8;
  localparam logic [7:0]  PWM_MASK_IDX = 8'h08;
endpackage

// File: rtl/pwm_ctl_regs.sv
module pwm_ctl_regs #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned IDX_W    = 8,
  parameter logic [IDX_W-1:0] MASK_IDX = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic [IDX_W-1:0]  idx_wdata,
  input  logic              dat_we,
  input  logic [BYTE_W-1:0] dat_wdata,
  output logic [BYTE_W-1:0] dat_rdata,
  output logic [BYTE_W-1:0] mask
);
  logic [IDX_W-1:0]  index_q;
  logic [BYTE_W-1:0] mask_q;
  logic              mask_hit;

  assign mask_hit = dat_we && (index_q == MASK_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) index_q <= '0;
    else if (idx_we) index_q <= idx_wdata;
  end

  // mask carries no reset value by design
  always_ff @(posedge clk) begin
    if (mask_hit) mask_q <= dat_wdata;
  end

  always_comb begin
    dat_rdata = '0;
    if (index_q == MASK_IDX) dat_rdata = mask_q;
  end

  assign mask = mask_q;

  p_mask_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_hit |=> (mask == $past(dat_wdata)));
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_hit && $past(rst_n)) |=> $stable(mask));
  p_rd_after_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_hit && !idx_we) |=> (dat_rdata == $past(dat_wdata)));
endmodule

// File: rtl/pwm_latch_bank.sv
module pwm_latch_bank #(
  parameter int unsigned PLANES = 4,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_valid,
  input  logic [PLANES*BYTE_W-1:0] ld_data,
  output logic [PLANES*BYTE_W-1:0] latch_q
);
  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    always_ff @(posedge clk) begin
      if (!rst_n) latch_q[p*BYTE_W +: BYTE_W] <= '0;
      else if (ld_valid) latch_q[p*BYTE_W +: BYTE_W] <= ld_data[p*BYTE_W +: BYTE_W];
    end
  end

  p_latch_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (latch_q == $past(ld_data)));
  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> $stable(latch_q));
endmodule

// File: rtl/pwm_plane_merge.sv
module pwm_plane_merge #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] new_byte,
  input  logic [BYTE_W-1:0] old_byte,
  input  logic [BYTE_W-1:0] mask,
  output logic [BYTE_W-1:0] merged
);
  assign merged = (new_byte & mask) | (old_byte & ~mask);
endmodule

// File: rtl/planar_wmask.sv
module planar_wmask
  import pwm_pkg::*;
#(
  parameter int unsigned PLANES = PWM_PLANES,
  parameter int unsigned BYTE_W = PWM_BYTE_W,
  parameter int unsigned IDX_W  = PWM_IDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     idx_we,
  input  logic [IDX_W-1:0]         idx_wdata,
  input  logic                     dat_we,
  input  logic [BYTE_W-1:0]        dat_wdata,
  output logic [BYTE_W-1:0]        dat_rdata,
  input  logic                     ld_valid,
  input  logic [PLANES*BYTE_W-1:0] ld_data,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [PLANES*BYTE_W-1:0] in_data,
  input  logic [PLANES-1:0]        in_plane_en,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [PLANES*BYTE_W-1:0] out_data,
  output logic [PLANES-1:0]        out_plane_en
);
  localparam int unsigned BUS_W = PLANES * BYTE_W;

  logic [BYTE_W-1:0] mask;
  logic [BUS_W-1:0]  latch_q;

  pwm_ctl_regs #(.BYTE_W(BYTE_W), .IDX_W(IDX_W), .MASK_IDX(IDX_W'(PWM_MASK_IDX))) u_regs (
    .clk(clk), .rst_n(rst_n),
    .idx_we(idx_we), .idx_wdata(idx_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata),
    .dat_rdata(dat_rdata), .mask(mask)
  );

  pwm_latch_bank #(.PLANES(PLANES), .BYTE_W(BYTE_W)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_data(ld_data), .latch_q(latch_q)
  );

  for (genvar p = 0; p < PLANES; p++) begin : g_merge
    pwm_plane_merge #(.BYTE_W(BYTE_W)) u_merge (
      .new_byte(in_data[p*BYTE_W +: BYTE_W]),
      .old_byte(latch_q[p*BYTE_W +: BYTE_W]),
      .mask(mask),
      .merged(out_data[p*BYTE_W +: BYTE_W])
    );
  end

  assign out_valid    = in_valid;
  assign in_ready     = out_ready;
  assign out_plane_en = in_plane_en;

  p_merge_new_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_data ^ in_data) & {PLANES{mask}}) == '0));
  p_merge_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_data ^ latch_q) & ~{PLANES{mask}}) == '0));
endmodule

// File: tb/test_planar_wmask.sv
module test_planar_wmask;
  logic clk = 1'b0;
  logic rst_n;
  logic idx_we, dat_we, ld_valid, in_valid, out_ready;
  logic [7:0] idx_wdata, dat_wdata, dat_rdata;
  logic [31:0] ld_data, in_data, out_data;
  logic [3:0] in_plane_en, out_plane_en;
  logic in_ready, out_valid;
  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  planar_wmask i_planar_wmask (
    .clk(clk), .rst_n(rst_n),
    .idx_we(idx_we), .idx_wdata(idx_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_plane_en(in_plane_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_plane_en(out_plane_en)
  );

  // {latch pattern, mask, processed data, expected merged}
  localparam logic [103:0] VEC [5] = '{
    {32'h00000000, 8'hFF, 32'hA5A5A5A5, 32'hA5A5A5A5},
    {32'hFFFFFFFF, 8'h00, 32'h12345678, 32'hFFFFFFFF},
    {32'hFFFFFFFF, 8'h0F, 32'h00000000, 32'hF0F0F0F0},
    {32'h12345678, 8'hF0, 32'hABCDEF01, 32'hA2C4E608},
    {32'h0F0F0F0F, 8'hAA, 32'hFFFFFFFF, 32'hAFAFAFAF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic set_index(input logic [7:0] v);
    idx_we = 1'b1; idx_wdata = v; tick(); idx_we = 1'b0;
  endtask

  task automatic set_data(input logic [7:0] v);
    dat_we = 1'b1; dat_wdata = v; tick(); dat_we = 1'b0;
  endtask

  task automatic load(input logic [31:0] v);
    ld_valid = 1'b1; ld_data = v; tick(); ld_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; idx_we = 0; dat_we = 0; ld_valid = 0; in_valid = 0; out_ready = 1;
    idx_wdata = 0; dat_wdata = 0; ld_data = 0; in_data = 0; in_plane_en = 4'hF;
    @(negedge clk); tick(); tick();
    rst_n = 1'b1;
    #1;
    // R1 reset index 00h reads zero
    check("R1", {24'h0, dat_rdata}, 32'h0);
    // R8 latches clear: program mask 00, write all ones
    set_index(8'h08); set_data(8'h00);
    in_valid = 1'b1; in_data = 32'hFFFFFFFF; #1;
    check("R8", out_data, 32'h0);
    in_valid = 1'b0;

    // R4 table walk
    foreach (VEC[i]) begin
      load(VEC[i][103:72]);
      set_data(VEC[i][71:64]);
      in_valid = 1'b1; in_data = VEC[i][63:32]; #1;
      check("R4", out_data, VEC[i][31:0]);
      tick(); in_valid = 1'b0;
    end

    // R1 readback at 08h, zero elsewhere
    set_data(8'h3C); #1;
    check("R1", {24'h0, dat_rdata}, 32'h3C);
    set_index(8'h07); #1;
    check("R1", {24'h0, dat_rdata}, 32'h0);
    // R2 data write at other index leaves mask alone
    set_data(8'h55);
    set_index(8'h08); #1;
    check("R2", {24'h0, dat_rdata}, 32'h3C);

    // R5 latches survive several transfers and a mask change
    load(32'hC3A55A3C);
    set_data(8'hFF);
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b1; in_data = 32'h11111111 * k; tick();
    end
    in_valid = 1'b0;
    set_data(8'h00);
    in_valid = 1'b1; in_data = 32'h0; #1;
    check("R5", out_data, 32'hC3A55A3C);
    in_valid = 1'b0;

    // R6 pass-through handshake and enables
    out_ready = 1'b0; in_valid = 1'b1; in_plane_en = 4'b0101; #1;
    check("R6", {29'h0, in_ready, out_valid, 1'b0}, {29'h0, 1'b0, 1'b1, 1'b0});
    check("R6", {28'h0, out_plane_en}, 32'h5);
    out_ready = 1'b1; in_valid = 1'b0; #1;
    check("R6", {30'h0, in_ready, out_valid}, 32'h2);
    in_plane_en = 4'hF;

    // R7 latch load in same cycle as write
    @(negedge clk);
    ld_valid = 1'b1; ld_data = 32'h0F1E2D3C; in_valid = 1'b1; in_data = 32'h0; #1;
    check("R7", out_data, 32'hC3A55A3C);
    tick(); ld_valid = 1'b0; #1;
    check("R7", out_data, 32'h0F1E2D3C);
    // R7 mask write in same cycle as write
    dat_we = 1'b1; dat_wdata = 8'hFF; in_data = 32'h99999999; #1;
    check("R7", out_data, 32'h0F1E2D3C);
    tick(); dat_we = 1'b0; #1;
    check("R7", out_data, 32'h99999999);
    in_valid = 1'b0;

    // R3 per-plane byte placement
    load(32'h44332211);
    set_data(8'h00);
    in_valid = 1'b1; #1;
    check("R3", out_data, 32'h44332211);
    in_valid = 1'b0;

    tick();
    finish_run();
  end
endmodule